// File: doc/BRIEF.md
# Two-Level Address Translator with Associative Cache

This block turns a 32-bit logical address into a physical address for 8 KB pages. Every request is first compared against a small fully associative translation cache. On a hit the frame number comes from the cache without touching memory. On a miss a hardware walker reads a two-level page table through a synchronous, single-port memory interface and then loads the result into the cache.

The 19-bit page number is split into a 10-bit upper index and a 9-bit lower index. The upper index selects an entry in the root table, which starts at a programmable base. That root entry points to a leaf table, and the lower index selects the leaf entry that holds the frame. The low 13 address bits are carried into the physical address unchanged.

A programmable page limit bounds the legal address space. The walker marks each leaf entry it resolves as referenced. A write also marks the entry dirty, and a write to a page without write permission is refused. Software writes the table base and the page limit through a configuration port. A flush input invalidates the whole cache in one cycle.

Top module: `addr_xlate`

## Requirements
- R1: After reset, resp_valid and mem_en are low, req_ready is high, and the page limit is zero, so every request faults with code 1.
- R2: A successful translation returns resp_fault 0 and resp_paddr = {frame number, logical address bits 12:0}. Any fault returns resp_paddr 0.
- R3: A request whose page number (address bits 31:13) is greater than or equal to the page limit (cfg_sel 1) returns fault code 1 one cycle after acceptance, with no memory access.
- R4: A miss first reads memory word base + address bits 31:22, where base is set with cfg_sel 0. If bit 0 (valid) of that root entry is clear, fault code 2 is returned three cycles after acceptance, after exactly one memory read.
- R5: A valid root entry supplies a leaf-table pointer in bits 31:13. The leaf entry is read at word {4'b0, pointer, address bits 21:13}. If its valid bit is clear, fault code 2 is returned five cycles after acceptance with no memory write.
- R6: A successful walk writes the leaf entry back to the same word with bit 1 (referenced) set. On a write request it also sets bit 2 (dirty). The response arrives six cycles after acceptance, after two reads and one write.
- R7: A read that hits in the cache responds one cycle after acceptance with no memory access.
- R8: A write to a page whose bit 3 (writable) is clear returns fault code 3. This takes one cycle if the page is cached, or five cycles after a walk that writes nothing back.
- R9: A write that hits a cached page not yet marked dirty re-walks the tables (six cycles) so that the dirty bit is set. A later write to that page then hits in one cycle.
- R10: A miss fills the lowest-numbered empty cache slot. When no slot is empty it replaces slots in round-robin order starting at slot 0 after reset. A page is never held in two slots.
- R11: A cycle with flush high invalidates every cache entry, so the next access to any page walks the tables.
- R12: Leaf-entry format: bit 0 valid, bit 1 referenced, bit 2 dirty, bit 3 writable, bits 31:13 frame number. The other fields of an entry with bit 0 clear are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cache entries |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base (word address), 1 selects page limit |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_addr | input | 32 | Logical address |
| req_write | input | 1 | Request is a write |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | 32 | Physical address |
| resp_fault | output | 2 | 0 none, 1 limit, 2 unmapped, 3 protection |
| mem_en | output | 1 | Table memory access enable |
| mem_we | output | 1 | Table memory write |
| mem_addr | output | 32 | Table memory word address |
| mem_wdata | output | 32 | Table memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read is issued |

## Verification
Each result has a fixed latency, counted in clock edges from the edge that accepts the request:
- one edge for limit faults, cache hits and cached protection faults;
- three edges for an empty root entry;
- five edges for an empty leaf entry or a walked protection fault;
- six edges for a completed walk.

The bench drives each request at a falling edge and then polls resp_valid at every later falling edge. It checks the measured edge count against the expected figure, together with the fault code and address. It also counts memory reads and writes during each request, so the walker's access pattern is checked as well as the response.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
    localparam int ADDR_W = 32;
    localparam int OFF_W  = 13;
    localparam int HI_W   = 10;
    localparam int LO_W   = 9;
    localparam int VPN_W  = HI_W + LO_W;
    localparam int PFN_W  = ADDR_W - OFF_W;
    localparam int PAD_W  = ADDR_W - PFN_W - LO_W;

    localparam int E_VALID = 0;
    localparam int E_REF   = 1;
    localparam int E_DIRTY = 2;
    localparam int E_WRITE = 3;

    typedef logic [VPN_W-1:0] vpn_t;
    typedef logic [PFN_W-1:0] pfn_t;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_LIMIT    = 2'd1,
        FLT_UNMAPPED = 2'd2,
        FLT_PROTECT  = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        W_IDLE, W_ROOT_RD, W_ROOT_WT, W_LEAF_RD, W_LEAF_WT, W_WBACK
    } wstate_e;

    typedef struct packed {
        logic valid;
        vpn_t vpn;
        pfn_t pfn;
        logic wr_ok;
        logic dirty;
    } tlb_ent_t;

    function automatic vpn_t page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic [HI_W-1:0] hi_idx(input vpn_t v);
        return v[VPN_W-1:LO_W];
    endfunction

    function automatic logic [LO_W-1:0] lo_idx(input vpn_t v);
        return v[LO_W-1:0];
    endfunction

    function automatic pfn_t frame_of(input logic [ADDR_W-1:0] e);
        return e[ADDR_W-1:OFF_W];
    endfunction
endpackage

// File: rtl/xlt_cfg.sv
module xlt_cfg (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] pt_base,
    output logic [31:0] pt_limit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pt_base  <= '0;
            pt_limit <= '0;
        end else if (cfg_we) begin
            if (cfg_sel) pt_limit <= cfg_wdata;
            else         pt_base  <= cfg_wdata;
        end
    end
endmodule

// File: rtl/xlt_tlb.sv
module xlt_tlb
    import xlt_pkg::*;
#(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  vpn_t          lk_vpn,
    output logic          hit,
    output logic [IW-1:0] hit_idx,
    output tlb_ent_t      hit_ent,
    output logic [N-1:0]  hit_vec,
    output logic [N-1:0]  valid_map,
    output logic [IW-1:0] vic_idx,
    output logic          vic_rr,
    input  logic          fill_en,
    input  logic [IW-1:0] fill_idx,
    input  tlb_ent_t      fill_ent,
    input  logic          fill_adv
);
    tlb_ent_t      ent_q [N];
    logic [IW-1:0] rr_q;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g]   = ent_q[g].valid && (ent_q[g].vpn == lk_vpn);
        assign valid_map[g] = ent_q[g].valid;
    end

    always_comb begin
        hit     = |hit_vec;
        hit_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (hit_vec[i]) hit_idx = IW'(i);
        hit_ent = ent_q[hit_idx];
        vic_rr  = 1'b1;
        vic_idx = rr_q;
        for (int i = N - 1; i >= 0; i--)
            if (!valid_map[i]) begin
                vic_idx = IW'(i);
                vic_rr  = 1'b0;
            end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) ent_q[i] <= '0;
            rr_q <= '0;
        end else begin
            if (flush) begin
                for (int i = 0; i < N; i++) ent_q[i].valid <= 1'b0;
            end else if (fill_en) begin
                ent_q[fill_idx] <= fill_ent;
                if (fill_adv)
                    rr_q <= (rr_q == IW'(N - 1)) ? '0 : IW'(rr_q + 1'b1);
            end
        end
    end
endmodule

// File: rtl/xlt_walker.sv
module xlt_walker
    import xlt_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [31:0]   req_addr,
    input  logic          req_write,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [31:0]   resp_paddr,
    output fault_e        resp_fault,
    input  logic [31:0]   pt_base,
    input  logic [31:0]   pt_limit,
    input  logic          hit,
    input  logic [IW-1:0] hit_idx,
    input  tlb_ent_t      hit_ent,
    input  logic [IW-1:0] vic_idx,
    input  logic          vic_rr,
    output logic          mem_en,
    output logic          mem_we,
    output logic [31:0]   mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          fill_en,
    output logic [IW-1:0] fill_idx,
    output tlb_ent_t      fill_ent,
    output logic          fill_adv
);
    wstate_e          st_q, st_d;
    vpn_t             vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    logic [IW-1:0]    slot_q;
    logic             adv_q;
    pfn_t             ptr_q;
    logic [31:0]      ent_q;

    logic             rsp_set;
    fault_e           rsp_flt;
    logic [31:0]      rsp_pa;
    logic             start_walk;
    logic             over;
    vpn_t             in_vpn;
    logic [31:0]      leaf_addr;

    assign in_vpn    = page_of(req_addr);
    assign over      = {{OFF_W{1'b0}}, in_vpn} >= pt_limit;
    assign leaf_addr = {{PAD_W{1'b0}}, ptr_q, lo_idx(vpn_q)};
    assign req_ready = (st_q == W_IDLE);

    always_comb begin
        st_d       = st_q;
        rsp_set    = 1'b0;
        rsp_flt    = FLT_NONE;
        rsp_pa     = '0;
        start_walk = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        fill_en    = 1'b0;
        fill_idx   = slot_q;
        fill_adv   = adv_q;
        fill_ent   = '{valid: 1'b1, vpn: vpn_q, pfn: frame_of(ent_q),
                       wr_ok: ent_q[E_WRITE], dirty: ent_q[E_DIRTY]};
        unique case (st_q)
            W_IDLE: if (req_valid) begin
                if (over) begin
                    rsp_set = 1'b1;
                    rsp_flt = FLT_LIMIT;
                end else if (hit && req_write && !hit_ent.wr_ok) begin
                    rsp_set = 1'b1;
                    rsp_flt = FLT_PROTECT;
                end else if (hit && (!req_write || hit_ent.dirty)) begin
                    rsp_set = 1'b1;
                    rsp_pa  = {hit_ent.pfn, req_addr[OFF_W-1:0]};
                end else begin
                    start_walk = 1'b1;
                    st_d       = W_ROOT_RD;
                end
            end
            W_ROOT_RD: begin
                mem_en   = 1'b1;
                mem_addr = pt_base + {{(32-HI_W){1'b0}}, hi_idx(vpn_q)};
                st_d     = W_ROOT_WT;
            end
            W_ROOT_WT: begin
                if (!mem_rdata[E_VALID]) begin
                    rsp_set = 1'b1;
                    rsp_flt = FLT_UNMAPPED;
                    st_d    = W_IDLE;
                end else begin
                    st_d = W_LEAF_RD;
                end
            end
            W_LEAF_RD: begin
                mem_en   = 1'b1;
                mem_addr = leaf_addr;
                st_d     = W_LEAF_WT;
            end
            W_LEAF_WT: begin
                if (!mem_rdata[E_VALID]) begin
                    rsp_set = 1'b1;
                    rsp_flt = FLT_UNMAPPED;
                    st_d    = W_IDLE;
                end else if (wr_q && !mem_rdata[E_WRITE]) begin
                    rsp_set = 1'b1;
                    rsp_flt = FLT_PROTECT;
                    st_d    = W_IDLE;
                end else begin
                    st_d = W_WBACK;
                end
            end
            W_WBACK: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = leaf_addr;
                mem_wdata = ent_q;
                fill_en   = 1'b1;
                rsp_set   = 1'b1;
                rsp_pa    = {frame_of(ent_q), off_q};
                st_d      = W_IDLE;
            end
            default: st_d = W_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= W_IDLE;
            vpn_q      <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            slot_q     <= '0;
            adv_q      <= 1'b0;
            ptr_q      <= '0;
            ent_q      <= '0;
            resp_valid <= 1'b0;
            resp_paddr <= '0;
            resp_fault <= FLT_NONE;
        end else begin
            st_q       <= st_d;
            resp_valid <= rsp_set;
            resp_paddr <= rsp_pa;
            resp_fault <= rsp_flt;
            if (start_walk) begin
                vpn_q  <= in_vpn;
                off_q  <= req_addr[OFF_W-1:0];
                wr_q   <= req_write;
                slot_q <= hit ? hit_idx : vic_idx;
                adv_q  <= !hit && vic_rr;
            end
            if (st_q == W_ROOT_WT) ptr_q <= frame_of(mem_rdata);
            if (st_q == W_LEAF_WT) begin
                ent_q          <= mem_rdata;
                ent_q[E_REF]   <= 1'b1;
                ent_q[E_DIRTY] <= mem_rdata[E_DIRTY] | wr_q;
            end
        end
    end
endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import xlt_pkg::*;
#(
    parameter int TLB_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        flush,
    input  logic        cfg_we,
    input  logic        cfg_sel,
    input  logic [31:0] cfg_wdata,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    output logic        resp_valid,
    output logic [31:0] resp_paddr,
    output logic [1:0]  resp_fault,
    output logic        mem_en,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    localparam int IW = (TLB_ENTRIES > 1) ? $clog2(TLB_ENTRIES) : 1;

    logic [31:0]          pt_base, pt_limit;
    logic                 tlb_hit, vic_rr, fill_en, fill_adv;
    logic [IW-1:0]        hit_idx, vic_idx, fill_idx;
    tlb_ent_t             hit_ent, fill_ent;
    logic [TLB_ENTRIES-1:0] tlb_hit_vec, tlb_valid_map;
    fault_e               flt;

    assign resp_fault = flt;

    xlt_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .pt_base(pt_base), .pt_limit(pt_limit)
    );

    xlt_tlb #(.N(TLB_ENTRIES), .IW(IW)) u_tlb (
        .clk(clk), .rst(rst), .flush(flush), .lk_vpn(page_of(req_addr)),
        .hit(tlb_hit), .hit_idx(hit_idx), .hit_ent(hit_ent),
        .hit_vec(tlb_hit_vec), .valid_map(tlb_valid_map),
        .vic_idx(vic_idx), .vic_rr(vic_rr),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_ent(fill_ent),
        .fill_adv(fill_adv)
    );

    xlt_walker #(.IW(IW)) u_walk (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(flt),
        .pt_base(pt_base), .pt_limit(pt_limit),
        .hit(tlb_hit), .hit_idx(hit_idx), .hit_ent(hit_ent),
        .vic_idx(vic_idx), .vic_rr(vic_rr),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_ent(fill_ent),
        .fill_adv(fill_adv)
    );
endmodule

// File: rtl/xlt_chk.sv
module xlt_chk #(
    parameter int N = 8
) (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic        resp_valid,
    input logic [31:0] resp_paddr,
    input logic [1:0]  resp_fault,
    input logic        mem_en,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] pt_base,
    input logic [31:0] pt_limit,
    input logic        tlb_hit,
    input logic [N-1:0] tlb_hit_vec,
    input logic [N-1:0] tlb_valid_map
);
    logic acc, beyond;
    assign acc    = req_valid && req_ready;
    assign beyond = {13'd0, req_addr[31:13]} >= pt_limit;

    // R3
    limit_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && beyond) |=> (resp_valid && resp_fault == 2'd1 && !mem_en));

    // R7
    hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !beyond && tlb_hit && !req_write) |=>
        (resp_valid && resp_fault == 2'd0 && !mem_en));

    // R4
    root_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !beyond && !tlb_hit) |=>
        (mem_en && !mem_we && mem_addr == pt_base + {22'd0, $past(req_addr[31:22])}));

    // R6
    wback_ref_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_en && mem_wdata[1] && mem_wdata[0]));

    // R6
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !resp_valid);

    // R2
    fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault != 2'd0) |-> (resp_paddr == 32'd0));

    // R11
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (tlb_valid_map == '0));

    // R10
    single_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tlb_hit_vec));
endmodule

bind addr_xlate xlt_chk #(.N(TLB_ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr), .resp_fault(resp_fault),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pt_base(pt_base), .pt_limit(pt_limit),
    .tlb_hit(tlb_hit), .tlb_hit_vec(tlb_hit_vec), .tlb_valid_map(tlb_valid_map)
);

// File: tb/tb_addr_xlate.sv
`timescale 1ns/1ps
module tb_addr_xlate;
    localparam int BASE = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready, resp_valid, mem_en, mem_we;
    logic [31:0] resp_paddr, mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  resp_fault;

    int checks = 0, bad = 0;
    int n_rd = 0, n_wr = 0;
    logic [31:0] mem [0:4095];

    always #2.5 clk = ~clk;

    addr_xlate dut (.*);

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[11:0]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                n_rd <= n_rd + 1;
            end
            mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not complete");
        summary();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [18:0] pfn_of(input logic [18:0] v);
        return 19'(v * 5 + 19'h123);
    endfunction
    function automatic bit leaf_ok(input int lo);
        return (lo % 7) != 5;
    endfunction
    function automatic bit writable(input int lo);
        return (lo % 2) == 0;
    endfunction
    function automatic logic [31:0] va(input int hi, input int lo, input int off);
        return {10'(hi), 9'(lo), 13'(off)};
    endfunction
    function automatic int leaf_word(input int hi, input int lo);
        return (hi + 1) * 512 + lo;
    endfunction

    task automatic cfg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    int          r_lat, r_rd, r_wr;
    logic [1:0]  r_flt;
    logic [31:0] r_pa;

    task automatic xreq(input logic [31:0] a, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        n_rd = 0; n_wr = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_lat = 1;
        while (!resp_valid && r_lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            r_lat++;
        end
        r_flt = resp_fault; r_pa = resp_paddr; r_rd = n_rd; r_wr = n_wr;
    endtask

    initial begin
        for (int w = 0; w < 4096; w++) mem[w] = '0;
        for (int hi = 0; hi < 4; hi++) begin
            mem[BASE + hi] = {19'(hi + 1), 12'd0, 1'b1};
            for (int lo = 0; lo < 512; lo++)
                mem[leaf_word(hi, lo)] = {pfn_of({10'(hi), 9'(lo)}), 9'd0,
                                          1'(writable(lo)), 2'b00, 1'(leaf_ok(lo))};
        end

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 resp_valid after reset", 32'(resp_valid), 0);
        chk("R1 mem_en after reset", 32'(mem_en), 0);
        chk("R1 req_ready after reset", 32'(req_ready), 1);
        xreq(va(0, 0, 0), 1'b0);
        chk("R1 zero limit fault", 32'(r_flt), 1);

        cfg(1'b0, BASE);
        cfg(1'b1, 32'h8_0000);

        // R10: fill 8 empty slots, then round-robin from slot 0
        for (int k = 0; k < 9; k++) begin
            xreq(va(0, (k < 5) ? k : k + 1, 4), 1'b0);
            chk("R10 fill latency", r_lat, 6);
        end
        xreq(va(0, 1, 4), 1'b0);
        chk("R10 survivor hit", r_lat, 1);
        xreq(va(0, 0, 4), 1'b0);
        chk("R10 evicted slot0 re-walk", r_lat, 6);
        xreq(va(0, 2, 4), 1'b0);
        chk("R10 survivor hit 2", r_lat, 1);
        xreq(va(0, 1, 4), 1'b0);
        chk("R10 evicted slot1 re-walk", r_lat, 6);

        // sweep reads over root and leaf indices
        do_flush();
        for (int hi = 0; hi < 5; hi++)
            for (int lo = 0; lo < 12; lo++) begin
                int off = (lo * 37 + hi * 101 + 5) % 8192;
                for (int rep = 0; rep < 2; rep++) begin
                    xreq(va(hi, lo, off), 1'b0);
                    if (hi >= 4) begin
                        chk("R4 root unmapped fault", 32'(r_flt), 2);
                        chk("R4 root unmapped latency", r_lat, 3);
                        chk("R4 single read", r_rd, 1);
                    end else if (!leaf_ok(lo)) begin
                        chk("R5 leaf unmapped fault", 32'(r_flt), 2);
                        chk("R5 leaf unmapped latency", r_lat, 5);
                        chk("R5 no write", r_wr, 0);
                        chk("R2 fault paddr", r_pa, 0);
                    end else begin
                        chk("R2 paddr", r_pa, {pfn_of({10'(hi), 9'(lo)}), 13'(off)});
                        chk("R2 no fault", 32'(r_flt), 0);
                        if (rep == 0) begin
                            chk("R6 walk latency", r_lat, 6);
                            chk("R6 reads", r_rd, 2);
                            chk("R6 writes", r_wr, 1);
                            chk("R6 referenced set", 32'(mem[leaf_word(hi, lo)][1]), 1);
                            chk("R6 read leaves dirty clear", 32'(mem[leaf_word(hi, lo)][2]), 0);
                        end else begin
                            chk("R7 hit latency", r_lat, 1);
                            chk("R7 no memory access", r_rd + r_wr, 0);
                        end
                    end
                end
            end

        // writes
        do_flush();
        xreq(va(1, 20, 9), 1'b1);
        chk("R6 write walk latency", r_lat, 6);
        chk("R6 dirty set", 32'(mem[leaf_word(1, 20)][2]), 1);
        xreq(va(1, 21, 9), 1'b1);
        chk("R8 walked protect fault", 32'(r_flt), 3);
        chk("R8 walked protect latency", r_lat, 5);
        chk("R8 no write back", r_wr, 0);
        chk("R8 entry untouched", 32'(mem[leaf_word(1, 21)][2:1]), 0);
        xreq(va(1, 21, 9), 1'b0);
        xreq(va(1, 21, 9), 1'b1);
        chk("R8 cached protect fault", 32'(r_flt), 3);
        chk("R8 cached protect latency", r_lat, 1);
        xreq(va(1, 22, 3), 1'b0);
        xreq(va(1, 22, 3), 1'b1);
        chk("R9 clean write re-walk", r_lat, 6);
        chk("R9 dirty set", 32'(mem[leaf_word(1, 22)][2]), 1);
        xreq(va(1, 22, 3), 1'b1);
        chk("R9 dirty write hit", r_lat, 1);
        chk("R9 paddr", r_pa, {pfn_of({10'd1, 9'd22}), 13'd3});

        // R11 flush
        xreq(va(2, 30, 1), 1'b0);
        xreq(va(2, 30, 1), 1'b0);
        chk("R11 hit before flush", r_lat, 1);
        do_flush();
        xreq(va(2, 30, 1), 1'b0);
        chk("R11 walk after flush", r_lat, 6);

        // R3 limit boundary: limit 1027 pages
        cfg(1'b1, 32'd1027);
        xreq(va(2, 3, 7), 1'b0);
        chk("R3 limit fault", 32'(r_flt), 1);
        chk("R3 limit latency", r_lat, 1);
        chk("R3 no memory", r_rd + r_wr, 0);
        xreq(va(2, 2, 7), 1'b0);
        chk("R3 last legal page", 32'(r_flt), 0);
        chk("R3 last legal paddr", r_pa, {pfn_of({10'd2, 9'd2}), 13'd7});

        // R12: invalid leaf with other fields set is still unmapped
        cfg(1'b1, 32'h8_0000);
        mem[leaf_word(3, 40)] = 32'hFFFF_FFFE;
        xreq(va(3, 40, 0), 1'b1);
        chk("R12 invalid leaf ignored", 32'(r_flt), 2);

        summary();
    end
endmodule